// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Interface

This block is the device end of a serial memory link with four wires: a select, a serial clock, a data input and a data output. Behind it sits a 2 Kbit storage array, modelled here as plain registers. While the device is selected, the block ignores clock pulses until it sees a rising serial clock with data input high. That pulse is the start bit. The block then takes in a two-bit opcode, an address and, for the write forms, a data word. It then runs a read, a write, an erase or one of the extended commands.

Any write or erase starts a program cycle that the block times on its own. The cycle is a fixed number of system clocks, and no serial clock pulses are needed while it runs. The data output comes from an output enable and a data value, so the pad can be tri-stated. During a read this output carries the data. After a program cycle has begun, and the select has been dropped and raised again, it carries the ready/busy state. An organization input chooses 16-bit words or 8-bit words over the same array. In 16-bit mode, word w uses byte 2w as its low half and byte 2w+1 as its high half.

Top module: `eep3w_slave`

## Requirements
- R1: While the select input is low, the serial logic is held in its idle state and the output enable is low (high-impedance). Dropping the select partway through an instruction abandons that instruction.
- R2: A program cycle lasts PROG_CYCLES system clocks from the serial edge that completes the instruction. It runs to the end whether or not the select stays high.
- R3: All inputs are taken on rising serial clock edges. For a read, the edge that takes the last address bit drives a 0 dummy bit. Each of the next word-width edges drives one data bit, most significant bit first. The edge after the last data bit releases the output.
- R4: While selected and waiting for a start bit, any number of rising edges with data input 0 leaves the block waiting. An instruction that follows still decodes normally.
- R5: Once an instruction has been fully received, further clocks and data are ignored and the output stays released until the select goes low.
- R6: If the select is raised after a program cycle has begun, the output is enabled and shows 0 while the cycle runs and 1 once it has ended.
- R7: If the select stays low for a whole program cycle, the output stays released. Raising the select afterwards shows ready (1).
- R8: A start bit received while ready status is shown removes the status from the output.
- R9: With the organization input high, the array is 128 words of 16 bits with a 7-bit address. With it low, the array is 256 words of 8 bits with an 8-bit address.
- R10: Opcode 10 reads, opcode 01 writes the data that follows, and opcode 11 erases the addressed word to all ones.
- R11: Opcode 00 uses the two most significant address bits as a sub-command: 11 enables writing, 00 disables it, 10 erases the whole array to all ones, and 01 writes the following data word to every location.
- R12: Writing starts disabled after reset. While disabled, write, erase, erase-all and write-all change no storage and start no program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; also times the program cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Device select, active high |
| sclk_i | input | 1 | Serial clock, sampled by clk_i |
| sdi_i | input | 1 | Serial data input |
| org_i | input | 1 | Word organization: 1 = 16-bit words, 0 = 8-bit words |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |

## Verification
Assertions check some behaviour on every cycle. A low select forces the idle state with the output released. Idle clocks with data input 0 do not move the controller. A finished instruction stays finished while selected. A read keeps the output driven. A program cycle never restarts while busy and keeps running once begun. The status display is never shown without being armed. Other behaviour shows only in the bench's serial sessions: read data comes back bit-exact in both organizations, including bytes shared between 16-bit and 8-bit views. Write-enable gating and the extended commands are observed through later reads. The exact busy and ready values appear at the points where the select is toggled.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_DATA,
      ST_READ,
      ST_DONE
   } ser_st_e;

   typedef enum logic [1:0] {
      MEM_NONE,
      MEM_WORD,
      MEM_FILL
   } mem_cmd_e;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] EXT_LOCK   = 2'b00;
   localparam logic [1:0] EXT_FILL   = 2'b01;
   localparam logic [1:0] EXT_WIPE   = 2'b10;
   localparam logic [1:0] EXT_UNLOCK = 2'b11;

endpackage

// File: rtl/eep3w_prog_timer.sv
module eep3w_prog_timer #(
   parameter int PROG_CYCLES = 64
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o
);
   localparam int CNT_W = $clog2(PROG_CYCLES + 1);

   if (PROG_CYCLES < 2) begin : g_bad_cycles
      $error("PROG_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= CNT_W'(PROG_CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);

   AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |-> !busy_o); // R2
   AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> busy_o); // R2
   AST_BUSY_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && cnt_q > CNT_W'(1)) |=> busy_o); // R2

endmodule

// File: rtl/eep3w_store.sv
module eep3w_store
   import eep3w_pkg::*;
#(
   parameter int WADDR_W    = 7,
   parameter int BYTE_W     = 8,
   parameter bit RESET_FILL = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  mem_cmd_e              cmd_i,
   input  logic                  org_i,
   input  logic [WADDR_W:0]      addr_i,
   input  logic [2*BYTE_W-1:0]   wdata_i,
   output logic [2*BYTE_W-1:0]   rdata_o
);
   localparam int BADDR_W = WADDR_W + 1;
   localparam int NBYTES  = 1 << BADDR_W;
   localparam int WORD_W  = 2 * BYTE_W;

   if (WADDR_W < 2) begin : g_bad_addr
      $error("WADDR_W must be at least 2 to hold a sub-command");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be positive");
   end

   logic [BYTE_W-1:0]  mem_q [NBYTES];
   logic [BYTE_W-1:0]  mem_d [NBYTES];
   logic [BADDR_W-1:0] hi_idx, lo_idx;

   assign hi_idx = {addr_i[WADDR_W-1:0], 1'b1};
   assign lo_idx = {addr_i[WADDR_W-1:0], 1'b0};

   always_comb begin
      mem_d = mem_q;
      unique case (cmd_i)
         MEM_WORD: begin
            if (org_i) begin
               mem_d[hi_idx] = wdata_i[WORD_W-1:BYTE_W];
               mem_d[lo_idx] = wdata_i[BYTE_W-1:0];
            end else begin
               mem_d[addr_i] = wdata_i[BYTE_W-1:0];
            end
         end
         MEM_FILL: begin
            for (int i = 0; i < NBYTES; i++) begin
               mem_d[i] = (org_i && (i % 2 == 1)) ? wdata_i[WORD_W-1:BYTE_W]
                                                  : wdata_i[BYTE_W-1:0];
            end
         end
         default: ;
      endcase
   end

   if (RESET_FILL) begin : g_reset_ones
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 0; i < NBYTES; i++) mem_q[i] <= '1;
         end else begin
            mem_q <= mem_d;
         end
      end
   end else begin : g_no_reset
      always_ff @(posedge clk_i) begin
         mem_q <= mem_d;
      end
   end

   assign rdata_o = org_i ? {mem_q[hi_idx], mem_q[lo_idx]}
                          : {{BYTE_W{1'b0}}, mem_q[addr_i]};

endmodule

// File: rtl/eep3w_serial.sv
module eep3w_serial
   import eep3w_pkg::*;
#(
   parameter int WADDR_W = 7,
   parameter int BYTE_W  = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                cs_i,
   input  logic                sclk_i,
   input  logic                sdi_i,
   input  logic                org_i,
   input  logic                busy_i,
   input  logic [2*BYTE_W-1:0] rdata_i,
   output mem_cmd_e            cmd_o,
   output logic [WADDR_W:0]    addr_o,
   output logic [2*BYTE_W-1:0] wdata_o,
   output logic                prog_o,
   output logic                start_seen_o,
   output logic                sdo_o,
   output logic                drv_o
);
   localparam int BADDR_W = WADDR_W + 1;
   localparam int WORD_W  = 2 * BYTE_W;
   localparam int CNT_W   = $clog2(WORD_W + BADDR_W + 1);

   ser_st_e             st_q, st_d;
   logic [CNT_W-1:0]    cnt_q, cnt_d;
   logic [1:0]          op_q, op_d;
   logic [BADDR_W-1:0]  addr_q, addr_d, addr_sh;
   logic [WORD_W-1:0]   data_q, data_d, data_sh;
   logic [WORD_W-1:0]   rsh_q, rsh_d;
   logic                sdo_q, sdo_d, drv_q, drv_d, wen_q, wen_d;
   logic                sclk_q, rise;
   logic [1:0]          ext;
   logic [CNT_W-1:0]    alast, dlen;

   assign rise    = cs_i & sclk_i & ~sclk_q;
   assign addr_sh = {addr_q[BADDR_W-2:0], sdi_i};
   assign data_sh = {data_q[WORD_W-2:0], sdi_i};
   assign ext     = org_i ? addr_sh[WADDR_W-1 -: 2] : addr_sh[BADDR_W-1 -: 2];
   assign alast   = org_i ? CNT_W'(WADDR_W - 1) : CNT_W'(BADDR_W - 1);
   assign dlen    = org_i ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);

   always_comb begin
      st_d = st_q;   cnt_d = cnt_q;  op_d = op_q;   addr_d = addr_q;
      data_d = data_q; rsh_d = rsh_q; sdo_d = sdo_q; drv_d = drv_q;
      wen_d = wen_q;
      cmd_o = MEM_NONE; prog_o = 1'b0; start_seen_o = 1'b0;
      addr_o = addr_q; wdata_o = data_q;
      if (!cs_i) begin
         st_d = ST_IDLE; cnt_d = '0; drv_d = 1'b0;
      end else if (rise) begin
         unique case (st_q)
            ST_IDLE: begin
               if (sdi_i && !busy_i) begin
                  st_d = ST_OPC; cnt_d = '0; start_seen_o = 1'b1;
               end
            end
            ST_OPC: begin
               op_d = {op_q[0], sdi_i};
               if (cnt_q == CNT_W'(1)) begin
                  st_d = ST_ADDR; cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            ST_ADDR: begin
               addr_d = addr_sh;
               addr_o = addr_sh;
               if (cnt_q == alast) begin
                  cnt_d = '0;
                  st_d  = ST_DONE;
                  unique case (op_q)
                     OP_READ: begin
                        st_d = ST_READ; rsh_d = rdata_i; sdo_d = 1'b0; drv_d = 1'b1;
                     end
                     OP_WRITE: st_d = ST_DATA;
                     OP_ERASE: begin
                        if (wen_q) begin
                           cmd_o = MEM_WORD; wdata_o = '1; prog_o = 1'b1;
                        end
                     end
                     default: begin
                        unique case (ext)
                           EXT_UNLOCK: wen_d = 1'b1;
                           EXT_LOCK:   wen_d = 1'b0;
                           EXT_FILL:   st_d  = ST_DATA;
                           default: begin
                              if (wen_q) begin
                                 cmd_o = MEM_FILL; wdata_o = '1; prog_o = 1'b1;
                              end
                           end
                        endcase
                     end
                  endcase
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            ST_DATA: begin
               data_d = data_sh;
               if (cnt_q == dlen - 1'b1) begin
                  st_d = ST_DONE; cnt_d = '0;
                  if (wen_q) begin
                     cmd_o   = (op_q == OP_EXT) ? MEM_FILL : MEM_WORD;
                     wdata_o = data_sh;
                     prog_o  = 1'b1;
                  end
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            ST_READ: begin
               if (cnt_q == dlen) begin
                  drv_d = 1'b0; st_d = ST_DONE;
               end else begin
                  sdo_d = org_i ? rsh_q[WORD_W-1] : rsh_q[BYTE_W-1];
                  rsh_d = {rsh_q[WORD_W-2:0], 1'b0};
                  cnt_d = cnt_q + 1'b1;
               end
            end
            ST_DONE: ;
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q <= ST_IDLE; cnt_q <= '0; op_q <= '0; addr_q <= '0;
         data_q <= '0; rsh_q <= '0; sdo_q <= 1'b0; drv_q <= 1'b0;
         wen_q <= 1'b0; sclk_q <= 1'b0;
      end else begin
         st_q <= st_d; cnt_q <= cnt_d; op_q <= op_d; addr_q <= addr_d;
         data_q <= data_d; rsh_q <= rsh_d; sdo_q <= sdo_d; drv_q <= drv_d;
         wen_q <= wen_d; sclk_q <= sclk_i;
      end
   end

   assign sdo_o = sdo_q;
   assign drv_o = drv_q;

   AST_CS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_i |=> (st_q == ST_IDLE && !drv_q)); // R1
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_IDLE && !sdi_i) |=> st_q == ST_IDLE); // R4
   AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_DONE && cs_i) |=> (st_q == ST_DONE && !drv_q)); // R5
   AST_READ_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_q == ST_READ |-> drv_q); // R3

endmodule

// File: rtl/eep3w_slave.sv
module eep3w_slave
   import eep3w_pkg::*;
#(
   parameter int WADDR_W     = 7,
   parameter int BYTE_W      = 8,
   parameter int PROG_CYCLES = 64,
   parameter bit RESET_FILL  = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cs_i,
   input  logic sclk_i,
   input  logic sdi_i,
   input  logic org_i,
   output logic sdo_o,
   output logic sdo_oe_o
);
   localparam int WORD_W = 2 * BYTE_W;

   mem_cmd_e            cmd;
   logic [WADDR_W:0]    addr;
   logic [WORD_W-1:0]   wdata, rdata;
   logic                prog, start_seen, ser_sdo, ser_drv, busy;
   logic                cs_q, stat_arm_q, stat_show_q;

   eep3w_serial #(.WADDR_W(WADDR_W), .BYTE_W(BYTE_W)) u_serial (
      .clk_i, .rst_ni, .cs_i, .sclk_i, .sdi_i, .org_i,
      .busy_i(busy), .rdata_i(rdata), .cmd_o(cmd), .addr_o(addr),
      .wdata_o(wdata), .prog_o(prog), .start_seen_o(start_seen),
      .sdo_o(ser_sdo), .drv_o(ser_drv)
   );

   eep3w_store #(.WADDR_W(WADDR_W), .BYTE_W(BYTE_W), .RESET_FILL(RESET_FILL)) u_store (
      .clk_i, .rst_ni, .cmd_i(cmd), .org_i, .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata)
   );

   eep3w_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk_i, .rst_ni, .start_i(prog), .busy_o(busy)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_q <= 1'b0; stat_arm_q <= 1'b0; stat_show_q <= 1'b0;
      end else begin
         cs_q <= cs_i;
         if (prog) begin
            stat_arm_q <= 1'b1; stat_show_q <= 1'b0;
         end else if (start_seen) begin
            stat_arm_q <= 1'b0; stat_show_q <= 1'b0;
         end else if (cs_i && !cs_q && stat_arm_q) begin
            stat_show_q <= 1'b1;
         end
      end
   end

   assign sdo_o    = stat_show_q ? ~busy : ser_sdo;
   assign sdo_oe_o = cs_i & (stat_show_q | ser_drv);

   AST_SHOW_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_show_q |-> stat_arm_q); // R6

endmodule

// File: tb/eep3w_slave_test.sv
module eep3w_slave_test;
   localparam int PROG = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b1;
   logic sdo, sdo_oe;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   logic [15:0] exp_q [$];
   string       tag_q [$];
   logic [7:0]  mdl [256];
   bit          mon_on = 1'b0;
   int          mon_bits = 16;

   always #10 clk = ~clk;

   eep3w_slave #(.PROG_CYCLES(PROG)) uut (
      .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
      .org_i(org), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic sbit(input logic b);
      @(negedge clk); sdi = b; sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
   endtask

   task automatic sel_low();
      @(negedge clk); cs = 1'b0; sdi = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic instr(input logic o, input logic [1:0] op, input logic [7:0] a,
                        input bit has_d, input logic [15:0] d);
      @(negedge clk); org = o; cs = 1'b1;
      repeat (2) @(negedge clk);
      sbit(1'b1); sbit(op[1]); sbit(op[0]);
      for (int i = (o ? 6 : 7); i >= 0; i--) sbit(a[i]);
      if (has_d) for (int i = (o ? 15 : 7); i >= 0; i--) sbit(d[i]);
   endtask

   task automatic wait_prog();
      sel_low();
      repeat (PROG + 10) @(negedge clk);
   endtask

   task automatic rd(input logic o, input logic [7:0] a, input int idle, input string req);
      logic [15:0] e;
      e = o ? {mdl[{a[6:0], 1'b1}], mdl[{a[6:0], 1'b0}]} : {8'h00, mdl[a]};
      exp_q.push_back(e); tag_q.push_back(req);
      @(negedge clk); org = o; cs = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < idle; i++) sbit(1'b0);
      sbit(1'b1); sbit(1'b1); sbit(1'b0);
      for (int i = (o ? 6 : 7); i >= 0; i--) sbit(a[i]);
      chk(sdo_oe === 1'b1 && sdo === 1'b0, "R3 dummy bit", {14'd0, sdo_oe, sdo}, 16'h0002);
      mon_bits = o ? 16 : 8; mon_on = 1'b1;
      for (int i = 0; i < mon_bits; i++) sbit(1'b0);
      mon_on = 1'b0;
      sbit(1'b0);
      chk(sdo_oe === 1'b0, "R3 release after data", {15'd0, sdo_oe}, 16'h0000);
      sbit(1'b1); sbit(1'b1); sbit(1'b1);
      chk(sdo_oe === 1'b0, "R5 ignore after instruction", {15'd0, sdo_oe}, 16'h0000);
      sel_low();
   endtask

   // monitor: collects read bits at each falling serial clock and scores them
   initial begin
      logic [15:0] word;
      int n;
      word = '0; n = 0;
      forever begin
         @(negedge sclk);
         if (mon_on) begin
            word = {word[14:0], sdo};
            n++;
            if (n == mon_bits) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "scoreboard empty", word, 16'hxxxx);
               end else begin
                  logic [15:0] e;
                  string t;
                  e = exp_q.pop_front(); t = tag_q.pop_front();
                  chk(word === e, t, word, e);
               end
               n = 0; word = '0;
            end
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(sdo_oe === 1'b0, "R1 reset output released", {15'd0, sdo_oe}, 16'h0000);

      // R1: abandoned partial instruction, then a normal read
      @(negedge clk); cs = 1'b1;
      sbit(1'b1); sbit(1'b1);
      sel_low();
      chk(sdo_oe === 1'b0, "R1 select low mid-instruction", {15'd0, sdo_oe}, 16'h0000);
      rd(1'b1, 8'h05, 0, "R1 R12 read after abort");

      // R12: write while locked does nothing
      instr(1'b1, 2'b01, 8'h05, 1'b1, 16'h1234);
      wait_prog();
      @(negedge clk); cs = 1'b1; repeat (2) @(negedge clk);
      chk(sdo_oe === 1'b0, "R12 no status when locked", {15'd0, sdo_oe}, 16'h0000);
      sel_low();
      rd(1'b1, 8'h05, 0, "R12 locked write ignored");

      // R11 unlock, then R6/R2 status during a write
      instr(1'b1, 2'b00, 8'h60, 1'b0, 16'h0); sel_low();
      instr(1'b1, 2'b01, 8'h05, 1'b1, 16'hA5C3);
      mdl[10] = 8'hC3; mdl[11] = 8'hA5;
      sel_low();
      @(negedge clk); cs = 1'b1; repeat (2) @(negedge clk);
      chk(sdo_oe === 1'b1 && sdo === 1'b0, "R6 busy shown", {14'd0, sdo_oe, sdo}, 16'h0002);
      sel_low();
      repeat (36) @(negedge clk);
      @(negedge clk); cs = 1'b1; repeat (2) @(negedge clk);
      chk(sdo_oe === 1'b1 && sdo === 1'b0, "R2 still busy after deselect", {14'd0, sdo_oe, sdo}, 16'h0002);
      repeat (30) @(negedge clk);
      chk(sdo_oe === 1'b1 && sdo === 1'b1, "R6 R2 ready shown", {14'd0, sdo_oe, sdo}, 16'h0003);
      sbit(1'b1);
      chk(sdo_oe === 1'b0, "R8 start bit clears status", {15'd0, sdo_oe}, 16'h0000);
      sel_low();

      rd(1'b1, 8'h05, 5, "R4 R10 read after idle clocks");

      // R7: select low for whole cycle, 8-bit organization
      instr(1'b0, 2'b01, 8'h0B, 1'b1, 16'h005A);
      mdl[11] = 8'h5A;
      wait_prog();
      @(negedge clk); cs = 1'b1; repeat (2) @(negedge clk);
      chk(sdo_oe === 1'b1 && sdo === 1'b1, "R7 ready after quiet cycle", {14'd0, sdo_oe, sdo}, 16'h0003);
      sel_low();

      rd(1'b0, 8'h0A, 0, "R9 byte view low half");
      rd(1'b0, 8'h0B, 0, "R9 byte view high half");
      rd(1'b1, 8'h05, 0, "R9 word view of bytes");

      // R10 erase of one word
      instr(1'b1, 2'b11, 8'h05, 1'b0, 16'h0);
      mdl[10] = 8'hFF; mdl[11] = 8'hFF;
      wait_prog();
      rd(1'b1, 8'h05, 0, "R10 word erase");

      // R11 write-all in byte mode, then erase-all
      instr(1'b0, 2'b00, 8'h40, 1'b1, 16'h0077);
      for (int i = 0; i < 256; i++) mdl[i] = 8'h77;
      wait_prog();
      rd(1'b0, 8'hFF, 0, "R11 write-all byte");
      rd(1'b1, 8'h00, 0, "R11 write-all word");
      instr(1'b1, 2'b00, 8'h40, 1'b0, 16'h0);
      for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
      wait_prog();
      rd(1'b1, 8'h7F, 0, "R11 erase-all");

      // R11 lock then R12 ignored write
      instr(1'b1, 2'b00, 8'h00, 1'b0, 16'h0); sel_low();
      instr(1'b1, 2'b01, 8'h03, 1'b1, 16'h1111);
      wait_prog();
      @(negedge clk); cs = 1'b1; repeat (2) @(negedge clk);
      chk(sdo_oe === 1'b0, "R12 relocked no program", {15'd0, sdo_oe}, 16'h0000);
      sel_low();
      rd(1'b1, 8'h03, 0, "R12 relocked write ignored");

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0000);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule